// File: doc/BRIEF.md
# Decimal and ASCII Adjust Unit

This unit corrects an 8-bit accumulator after arithmetic on decimal operands. It covers two packed-BCD corrections, one after addition and one after subtraction, where the byte holds two decimal digits. It also covers two unpacked corrections for add and subtract, where a digit sits in the low nibble and the high byte takes the carry or borrow. The last pair splits the low byte into a quotient and a remainder by a programmable base, and folds a two-digit pair back into one byte by the same base. The accumulator is given as a low byte and a high byte, together with the incoming carry and auxiliary-carry flags.

One operation is accepted per clock while `in_valid` is high. The new bytes and the carry, auxiliary, zero, sign and parity flags appear on registered outputs one clock later, and they hold until the next accepted operation. A split with a base of zero gives no quotient. Instead it raises `fault_o`, which leaves the bytes as they were and clears every flag.

Top module: `decadj_unit`

## Requirements
- R1: While `rst` is high at a clock edge, every output is driven to zero on that edge.
- R2: An operation accepted with `in_valid` high appears on the outputs at the next clock edge, with `out_valid` high. In a cycle with `in_valid` low, `out_valid` drops to 0 and all result outputs keep their previous values.
- R3: Op code 0, packed add adjust:
  - Let A = (low nibble > 9) or `af_in`. If A holds, 6 is added to the low byte.
  - Let C = (original low byte > 0x99) or `cf_in`. If C holds, a further 0x60 is added, with 8-bit wrap.
  - `af_o` = A and `cf_o` = C. The high byte passes through unchanged.
- R4: Op code 1, packed subtract adjust:
  - On the same nibble condition A, 6 is subtracted and `af_o` is set. If the original byte was below 6 or `cf_in` was set, `cf_o` is also set.
  - If the original byte is above 0x99 or `cf_in` is set, a further 0x60 is subtracted and `cf_o` is set.
  - All subtraction wraps at 8 bits. The high byte passes through unchanged.
- R5: Op code 2, unpacked add adjust:
  - When (low nibble > 9) or `af_in`, the low byte becomes (low+6)&0x0F. The high byte grows by 1, plus one more when the low byte exceeds 0xF9. `cf_o` and `af_o` are both 1.
  - Otherwise the low byte is masked to its low nibble, the high byte is unchanged, and both flags are 0.
- R6: Op code 3, unpacked subtract adjust:
  - Same condition as R5. The low byte becomes (low-6)&0x0F, and the high byte drops by 1, plus one more when the low byte is below 6. Both flags are 1.
  - Otherwise the low byte is masked, the high byte is unchanged, and both flags are 0.
- R7: Op code 4, split adjust with a nonzero base: the high byte becomes low/base and the low byte becomes low%base. `cf_o` and `af_o` are 0.
- R8: Op code 4 with a base of zero: `fault_o` is 1, both bytes equal the inputs, and all five flags are 0. Every other case gives `fault_o` = 0.
- R9: Op code 5, join adjust: the low byte becomes (high*base + low) mod 256 and the high byte becomes 0. `cf_o` and `af_o` are 0.
- R10: For every result without a fault, the zero, sign and parity flags are taken from the result low byte:
  - `zf_o` is 1 when that byte is 0.
  - `sf_o` is its bit 7.
  - `pf_o` is 1 when it has an even number of set bits.
- R11: Op codes 6 and 7 pass both bytes through unchanged, with `cf_o` and `af_o` at 0 and the other flags as in R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept an operation this cycle |
| op_sel | input | 3 | Operation code (0 to 7, see requirements) |
| lo_in | input | 8 | Accumulator low byte |
| hi_in | input | 8 | Accumulator high byte |
| cf_in | input | 1 | Incoming carry flag |
| af_in | input | 1 | Incoming auxiliary-carry flag |
| base_in | input | 8 | Base for split and join |
| out_valid | output | 1 | Result registered this cycle |
| lo_o | output | 8 | Result low byte |
| hi_o | output | 8 | Result high byte |
| cf_o | output | 1 | Carry out |
| af_o | output | 1 | Auxiliary carry out |
| zf_o | output | 1 | Zero flag |
| sf_o | output | 1 | Sign flag |
| pf_o | output | 1 | Even-parity flag |
| fault_o | output | 1 | Split with zero base |

## Verification
The only state in the unit is its output register, so any wrong value shows up on the ports one clock after the operation that caused it. The sweeps cover every low byte under every combination of the two incoming flags, and many bases for split and join. This exposes a wrong nibble threshold, a missing second increment on low-byte wrap, or a wrong borrow rule within one cycle of the faulty vector. A broken hold path shows as a changed output in an idle cycle.

// File: rtl/decadj_pkg.sv
package decadj_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;

  typedef enum logic [2:0] {
    OP_PK_ADD = 3'd0,
    OP_PK_SUB = 3'd1,
    OP_UN_ADD = 3'd2,
    OP_UN_SUB = 3'd3,
    OP_SPLIT  = 3'd4,
    OP_JOIN   = 3'd5,
    OP_RSV6   = 3'd6,
    OP_RSV7   = 3'd7
  } adj_op_e;

  typedef struct packed {
    logic fault;
    logic pf;
    logic sf;
    logic zf;
    logic af;
    logic cf;
    logic [BYTE_W-1:0] hi;
    logic [BYTE_W-1:0] lo;
  } adj_res_t;

  function automatic logic even_par(input logic [BYTE_W-1:0] v);
    return ~(^v);
  endfunction
endpackage

// File: rtl/decadj_bcd.sv
// Packed two-digit correction for add or subtract.
module decadj_bcd #(
  parameter int W = decadj_pkg::BYTE_W
) (
  input  logic [W-1:0] lo_i,
  input  logic         cf_i,
  input  logic         af_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic         cf_o,
  output logic         af_o
);
  localparam logic [W-1:0] LO_FIX  = W'(6);
  localparam logic [W-1:0] HI_FIX  = W'(8'h60);
  localparam logic [W-1:0] HI_LIM  = W'(8'h99);
  localparam logic [3:0]   NIB_LIM = 4'd9;

  logic         nib_hit, byte_hit, early_bor;
  logic [W-1:0] step1;

  always_comb begin
    nib_hit   = (lo_i[3:0] > NIB_LIM) | af_i;
    byte_hit  = (lo_i > HI_LIM) | cf_i;
    early_bor = sub_i & nib_hit & ((lo_i < LO_FIX) | cf_i);
    if (nib_hit) step1 = sub_i ? lo_i - LO_FIX : lo_i + LO_FIX;
    else         step1 = lo_i;
    if (byte_hit) res_o = sub_i ? step1 - HI_FIX : step1 + HI_FIX;
    else          res_o = step1;
    af_o = nib_hit;
    cf_o = byte_hit | early_bor;
  end
endmodule

// File: rtl/decadj_ascii.sv
// Unpacked single-digit correction with carry or borrow into the high byte.
module decadj_ascii #(
  parameter int W = decadj_pkg::BYTE_W
) (
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  input  logic         af_i,
  input  logic         sub_i,
  output logic [W-1:0] lo_o,
  output logic [W-1:0] hi_o,
  output logic         adj_o
);
  localparam logic [W-1:0] LO_FIX   = W'(6);
  localparam logic [W-1:0] WRAP_LIM = W'(8'hF9);
  localparam logic [3:0]   NIB_LIM  = 4'd9;

  logic         hit, extra;
  logic [W-1:0] moved, step;

  always_comb begin
    hit   = (lo_i[3:0] > NIB_LIM) | af_i;
    extra = sub_i ? (lo_i < LO_FIX) : (lo_i > WRAP_LIM);
    step  = extra ? W'(2) : W'(1);
    moved = sub_i ? lo_i - LO_FIX : lo_i + LO_FIX;
    if (hit) begin
      lo_o = {{(W-4){1'b0}}, moved[3:0]};
      hi_o = sub_i ? hi_i - step : hi_i + step;
    end else begin
      lo_o = {{(W-4){1'b0}}, lo_i[3:0]};
      hi_o = hi_i;
    end
    adj_o = hit;
  end
endmodule

// File: rtl/decadj_scale.sv
// Split by base (restoring divider) or join by base (multiply-add).
module decadj_scale #(
  parameter int W = decadj_pkg::BYTE_W
) (
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] base_i,
  input  logic         join_i,
  output logic [W-1:0] lo_o,
  output logic [W-1:0] hi_o,
  output logic         fault_o
);
  logic [W-1:0] rem_s [0:W];
  logic [W-1:0] quo;
  logic [W-1:0] prod;

  assign rem_s[0] = '0;

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_div
      logic [W:0] part;
      logic       ge;
      assign part = {rem_s[g], lo_i[W-1-g]};
      assign ge   = part >= {1'b0, base_i};
      assign quo[W-1-g] = ge;
      assign rem_s[g+1] = ge ? W'(part - {1'b0, base_i}) : part[W-1:0];
    end
  endgenerate

  assign prod = hi_i * base_i;

  always_comb begin
    fault_o = 1'b0;
    if (join_i) begin
      lo_o = prod + lo_i;
      hi_o = '0;
    end else if (base_i == '0) begin
      lo_o    = lo_i;
      hi_o    = hi_i;
      fault_o = 1'b1;
    end else begin
      lo_o = rem_s[W];
      hi_o = quo;
    end
  end
endmodule

// File: rtl/decadj_unit.sv
module decadj_unit
  import decadj_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        op_sel,
  input  logic [BYTE_W-1:0] lo_in,
  input  logic [BYTE_W-1:0] hi_in,
  input  logic              cf_in,
  input  logic              af_in,
  input  logic [BYTE_W-1:0] base_in,
  output logic              out_valid,
  output logic [BYTE_W-1:0] lo_o,
  output logic [BYTE_W-1:0] hi_o,
  output logic              cf_o,
  output logic              af_o,
  output logic              zf_o,
  output logic              sf_o,
  output logic              pf_o,
  output logic              fault_o
);
  adj_op_e op;
  assign op = adj_op_e'(op_sel);

  logic [BYTE_W-1:0] bcd_res, asc_lo, asc_hi, scl_lo, scl_hi;
  logic              bcd_cf, bcd_af, asc_adj, scl_fault;

  decadj_bcd #(.W(BYTE_W)) u_bcd (
    .lo_i(lo_in), .cf_i(cf_in), .af_i(af_in), .sub_i(op == OP_PK_SUB),
    .res_o(bcd_res), .cf_o(bcd_cf), .af_o(bcd_af)
  );

  decadj_ascii #(.W(BYTE_W)) u_asc (
    .lo_i(lo_in), .hi_i(hi_in), .af_i(af_in), .sub_i(op == OP_UN_SUB),
    .lo_o(asc_lo), .hi_o(asc_hi), .adj_o(asc_adj)
  );

  decadj_scale #(.W(BYTE_W)) u_scl (
    .lo_i(lo_in), .hi_i(hi_in), .base_i(base_in), .join_i(op == OP_JOIN),
    .lo_o(scl_lo), .hi_o(scl_hi), .fault_o(scl_fault)
  );

  adj_res_t nxt, cur;

  always_comb begin
    nxt = '0;
    nxt.lo = lo_in;
    nxt.hi = hi_in;
    unique case (op)
      OP_PK_ADD, OP_PK_SUB: begin
        nxt.lo = bcd_res;
        nxt.cf = bcd_cf;
        nxt.af = bcd_af;
      end
      OP_UN_ADD, OP_UN_SUB: begin
        nxt.lo = asc_lo;
        nxt.hi = asc_hi;
        nxt.cf = asc_adj;
        nxt.af = asc_adj;
      end
      OP_SPLIT, OP_JOIN: begin
        nxt.lo    = scl_lo;
        nxt.hi    = scl_hi;
        nxt.fault = scl_fault;
      end
      default: ;
    endcase
    if (!nxt.fault) begin
      nxt.zf = (nxt.lo == '0);
      nxt.sf = nxt.lo[BYTE_W-1];
      nxt.pf = even_par(nxt.lo);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur       <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) cur <= nxt;
    end
  end

  assign lo_o    = cur.lo;
  assign hi_o    = cur.hi;
  assign cf_o    = cur.cf;
  assign af_o    = cur.af;
  assign zf_o    = cur.zf;
  assign sf_o    = cur.sf;
  assign pf_o    = cur.pf;
  assign fault_o = cur.fault;
endmodule

// File: rtl/decadj_chk.sv
module decadj_chk
  import decadj_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [2:0]        op_sel,
  input logic [BYTE_W-1:0] lo_in,
  input logic [BYTE_W-1:0] base_in,
  input logic              out_valid,
  input logic [BYTE_W-1:0] lo_o,
  input logic [BYTE_W-1:0] hi_o,
  input logic              cf_o,
  input logic              af_o,
  input logic              fault_o
);
  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(lo_o) && $stable(hi_o)));

  // R5
  unpacked_nibble_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel[2:1] == 2'b01) |=> (lo_o[7:4] == 4'h0 && cf_o == af_o));

  // R7
  split_rem_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 3'd4 && base_in != '0) |=> (lo_o < $past(base_in) && !fault_o));

  // R8
  zero_base_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 3'd4 && base_in == '0) |=> (fault_o && lo_o == $past(lo_in)));

  // R9
  join_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 3'd5) |=> (hi_o == '0 && !cf_o && !af_o));
endmodule

bind decadj_unit decadj_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel), .lo_in(lo_in),
  .base_in(base_in), .out_valid(out_valid), .lo_o(lo_o), .hi_o(hi_o),
  .cf_o(cf_o), .af_o(af_o), .fault_o(fault_o)
);

// File: tb/decadj_unit_test.sv
`timescale 1ns/1ps
module decadj_unit_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [2:0] op_sel = '0;
  logic [7:0] lo_in = '0, hi_in = '0, base_in = '0;
  logic       cf_in = 1'b0, af_in = 1'b0;
  logic       out_valid, cf_o, af_o, zf_o, sf_o, pf_o, fault_o;
  logic [7:0] lo_o, hi_o;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  decadj_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
    .lo_in(lo_in), .hi_in(hi_in), .cf_in(cf_in), .af_in(af_in),
    .base_in(base_in), .out_valid(out_valid), .lo_o(lo_o), .hi_o(hi_o),
    .cf_o(cf_o), .af_o(af_o), .zf_o(zf_o), .sf_o(sf_o), .pf_o(pf_o),
    .fault_o(fault_o)
  );

  function automatic logic [22:0] snap();
    return {out_valid, fault_o, pf_o, sf_o, zf_o, af_o, cf_o, hi_o, lo_o};
  endfunction

  task automatic check(input string req, input logic [22:0] act, input logic [22:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s op=%0d lo=%02h hi=%02h cf=%0b af=%0b base=%02h act=%06h exp=%06h",
               req, op_sel, lo_in, hi_in, cf_in, af_in, base_in, act, exp);
    end
  endtask

  // Reference model from the requirements; returns {valid,fault,pf,sf,zf,af,cf,hi,lo}
  function automatic logic [22:0] model(input int op, input int lo, input int hi,
                                         input int cf, input int af, input int base);
    int r = lo, h = hi, c = 0, a = 0, flt = 0;
    logic [7:0] rb;
    case (op)
      0: begin
        a = ((lo & 15) > 9 || af) ? 1 : 0;
        r = a ? (lo + 6) & 255 : lo;
        c = (lo > 'h99 || cf) ? 1 : 0;
        if (c) r = (r + 'h60) & 255;
      end
      1: begin
        a = ((lo & 15) > 9 || af) ? 1 : 0;
        c = (a && (lo < 6 || cf)) ? 1 : 0;
        r = a ? (lo - 6) & 255 : lo;
        if (lo > 'h99 || cf) begin r = (r - 'h60) & 255; c = 1; end
      end
      2, 3: begin
        if ((lo & 15) > 9 || af) begin
          if (op == 2) begin r = (lo + 6) & 15; h = (hi + 1 + (lo > 'hF9 ? 1 : 0)) & 255; end
          else         begin r = (lo - 6) & 15; h = (hi - 1 - (lo < 6 ? 1 : 0)) & 255; end
          c = 1; a = 1;
        end else r = lo & 15;
      end
      4: begin
        if (base == 0) flt = 1;
        else begin h = lo / base; r = lo % base; end
      end
      5: begin r = (hi * base + lo) & 255; h = 0; end
      default: ;
    endcase
    rb = 8'(r);
    if (flt)
      return {1'b1, 1'b1, 5'b0, 8'(h), rb};
    return {1'b1, 1'b0, ($countones(rb) % 2 == 0), rb[7], (rb == 8'h00),
            a[0], c[0], 8'(h), rb};
  endfunction

  task automatic apply(input string req, input int op, input int lo, input int hi,
                       input int cf, input int af, input int base);
    @(negedge clk);
    in_valid = 1'b1; op_sel = 3'(op); lo_in = 8'(lo); hi_in = 8'(hi);
    cf_in = cf[0]; af_in = af[0]; base_in = 8'(base);
    @(negedge clk);
    check(req, snap(), model(op, lo, hi, cf, af, base));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    logic [22:0] held;
    repeat (3) @(negedge clk);
    check("R1", snap(), '0);
    @(negedge clk);
    rst = 1'b0;

    // R3 R4 R5 R6 R10: full sweep of low byte and both incoming flags
    for (int op = 0; op < 4; op++)
      for (int lo = 0; lo < 256; lo++)
        for (int fl = 0; fl < 4; fl++)
          apply(op == 0 ? "R3" : op == 1 ? "R4" : op == 2 ? "R5" : "R6",
                op, lo, (lo * 7 + op * 61) & 255, fl & 1, fl >> 1, lo);

    // R7 R8 R9: split and join over small and large bases
    for (int op = 4; op < 6; op++)
      for (int bi = 0; bi < 24; bi++) begin
        int base = (bi < 18) ? bi : 232 + bi;
        for (int lo = 0; lo < 256; lo++)
          apply(op == 5 ? "R9" : (base == 0 ? "R8" : "R7"),
                op, lo, (lo * 13 + base) & 255, lo & 1, (lo >> 1) & 1, base);
      end

    // R11: reserved codes pass through
    for (int op = 6; op < 8; op++)
      for (int lo = 0; lo < 256; lo += 3)
        apply("R11", op, lo, 255 - lo, 1, 1, lo);

    // R2: idle cycles hold the last result and drop out_valid
    apply("R2", 0, 'h9A, 'h12, 0, 0, 0);
    held = snap();
    @(negedge clk);
    in_valid = 1'b0; op_sel = 3'd3; lo_in = 8'h0F; hi_in = 8'h77; af_in = 1'b1;
    @(negedge clk);
    check("R2", snap(), {1'b0, held[21:0]});
    @(negedge clk);
    check("R2", snap(), {1'b0, held[21:0]});

    // R1: reset in mid-run clears everything
    rst = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    check("R1", snap(), '0);
    rst = 1'b0; in_valid = 1'b0;

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule